// File: doc/BRIEF.md
# SDRAM power-up initialization sequencer

This block brings an SDRAM out of power-up before any normal access is allowed. After a start pulse it issues a NOP and then waits out the power-up delay. Next it plays a fixed list of commands: a precharge, a burst of auto-refresh commands and finally a mode-register set. Between list commands it keeps a minimum spacing. Throughout the run it presents the configured timing word on its timing output with the two-bit refresh-control field held at zero. Once the last command has had its spacing it releases the full timing word, so that auto-refresh starts, and raises a sticky done flag.

The mode-register-set word is built inside the block. The CAS latency comes from the timing word and the data-bus width comes from the group-0 configuration word. A non-zero pre-supplied mode command overrides that calculation. Both delays are counted in clock cycles and derived from nanosecond parameters and the clock frequency, rounding up.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While done is low, `timing_out` equals `timing_cfg` with bits [REF_LSB+1:REF_LSB] (default [13:12]) cleared. While done is high, `timing_out` equals `timing_cfg` unchanged.
- R2: A start seen in the idle state gives, in the next cycle, a one-cycle `cmd_valid` with `cmd_word` equal to the NOP opcode. Opcodes sit in bits [1:0]: NOP=0, precharge=1, refresh=2, mode set=3.
- R3: The next strobe after the NOP comes exactly PWRUP_CYC cycles later, where PWRUP_CYC = ceil(PWRUP_NS*CLK_MHZ/1000).
- R4: After the NOP, exactly REF_BURST+2 strobes follow (default 10), each lasting one cycle: one precharge, REF_BURST (default 8) refresh commands, then one mode set. A whole run therefore has 11 strobes by default.
- R5: Successive list strobes are exactly GAP_CYC = ceil(GAP_NS*CLK_MHZ/1000) cycles apart.
- R6: Timing bits [2:0] equal to 2 select CAS latency 2. Any other value selects CAS latency 3.
- R7: Group-0 configuration bit 9 set means a 16-bit bus. Bit 9 clear means a 32-bit bus.
- R8: With no preset, the mode-set word is 3 | (M << 2). M is 0x40 for CL2/32-bit, 0x60 for CL3/32-bit, 0x20 for CL2/16-bit and 0x30 for CL3/16-bit. This gives 0x103, 0x183, 0x083 and 0x0C3.
- R9: A non-zero `preset_cmd` is issued unchanged as the mode-set word.
- R10: `done` rises exactly GAP_CYC cycles after the mode-set strobe. It stays high until reset, and no strobe occurs while it is high.
- R11: Start is ignored while a run is in progress and after done. Such a start adds no strobe and does not move any later strobe or done.
- R12: During and right after reset, `cmd_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches the sequence from idle |
| timing_cfg | input | TIM_W | Configured timing word (CAS latency in [2:0]) |
| grp0_cfg | input | CFG_W | Group-0 configuration word (bus width in bit 9) |
| preset_cmd | input | CMD_W | Pre-supplied mode command, zero selects automatic |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_word | output | CMD_W | Command word, valid with the strobe |
| timing_out | output | TIM_W | Timing word toward the controller, refresh gated |
| done | output | 1 | Initialization complete, sticky until reset |

## Verification
The sequence runs once for each of the four CAS-latency and bus-width combinations. These runs separate the CL2 test from a plain non-zero test and the width halving from a fixed value. One run uses a CAS field of 5, which shows that any value other than 2 falls back to CL3. One run uses a group word with every bit set except bit 9, which shows that only that bit selects the width. A preset run shows that the override replaces the calculated word. In every run the whole strobe list is timed against the start cycle, so the power-up delay, the list spacing, the order and the done cycle are each checked to the exact cycle. Start pulses during a run and after done confirm that the strobe count and timing stay unchanged.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LIST = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  // Nanoseconds to clock cycles, rounding up.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // Mode data before it is shifted into the command word.
  function automatic logic [6:0] mode_bits(input logic [2:0] cl_field,
                                           input logic       half_width);
    logic [6:0] base;
    base = (cl_field == 3'd2) ? 7'h40 : 7'h60;
    return half_width ? (base >> 1) : base;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_init_delay.sv
module sdram_init_delay #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_modecalc.sv
module sdram_init_modecalc
  import sdram_init_pkg::*;
#(
  parameter int              CMD_W  = 32,
  parameter logic [CMD_W-1:0] OP_MRS = 3
) (
  input  logic [2:0]       cl_field,
  input  logic             half_width,
  input  logic [CMD_W-1:0] preset_cmd,
  output logic [CMD_W-1:0] mrs_word
);
  logic [CMD_W-1:0] auto_word;
  logic             use_preset;

  assign auto_word  = OP_MRS | (CMD_W'(mode_bits(cl_field, half_width)) << 2);
  assign use_preset = (preset_cmd != '0);
  assign mrs_word   = use_preset ? preset_cmd : auto_word;
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int               PWRUP_CYC = 20000,
  parameter int               GAP_CYC   = 8,
  parameter int               REF_BURST = 8,
  parameter int               CMD_W     = 32,
  parameter int               CNT_W     = 16,
  parameter logic [CMD_W-1:0] OP_NOP    = 0,
  parameter logic [CMD_W-1:0] OP_PRE    = 1,
  parameter logic [CMD_W-1:0] OP_REF    = 2,
  parameter logic [CMD_W-1:0] OP_MRS    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CMD_W-1:0] mrs_word,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_word,
  output logic             idle,
  output logic             done
);
  localparam int LIST_LEN = REF_BURST + 2;
  localparam int IDX_W    = $clog2(LIST_LEN + 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q, done_q;
  logic [CMD_W-1:0] word_q;
  logic             fire_nop, fire_list, finish;

  // Entry of the command list by position; the last one is the mode set.
  function automatic logic [CMD_W-1:0] list_cmd(input logic [IDX_W-1:0] i,
                                                input logic [CMD_W-1:0] mrs);
    if (i == '0)                          return OP_PRE;
    else if (i == IDX_W'(LIST_LEN - 1))   return mrs;
    else                                  return OP_REF;
  endfunction

  always_comb begin
    fire_nop  = (state_q == ST_IDLE) && start;
    fire_list = (state_q == ST_LIST) && cnt_zero && (idx_q != IDX_W'(LIST_LEN));
    finish    = (state_q == ST_LIST) && cnt_zero && (idx_q == IDX_W'(LIST_LEN));
    cnt_load  = fire_nop || fire_list;
    cnt_val   = fire_nop ? CNT_W'(PWRUP_CYC - 1) : CNT_W'(GAP_CYC - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      valid_q <= 1'b0;
      word_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (fire_nop) begin
        valid_q <= 1'b1;
        word_q  <= OP_NOP;
        idx_q   <= '0;
        state_q <= ST_LIST;
      end else if (fire_list) begin
        valid_q <= 1'b1;
        word_q  <= list_cmd(idx_q, mrs_word);
        idx_q   <= idx_q + 1'b1;
      end else if (finish) begin
        done_q  <= 1'b1;
        state_q <= ST_DONE;
      end
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_word  = word_q;
  assign idle      = (state_q == ST_IDLE);
  assign done      = done_q;
endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_init_pkg::*;
#(
  parameter int               CLK_MHZ   = 100,
  parameter int               PWRUP_NS  = 200000,
  parameter int               GAP_NS    = 80,
  parameter int               REF_BURST = 8,
  parameter int               CMD_W     = 32,
  parameter int               TIM_W     = 32,
  parameter int               CFG_W     = 32,
  parameter int               REF_LSB   = 12,
  parameter int               WIDTH_BIT = 9,
  parameter logic [CMD_W-1:0] OP_NOP    = 0,
  parameter logic [CMD_W-1:0] OP_PRE    = 1,
  parameter logic [CMD_W-1:0] OP_REF    = 2,
  parameter logic [CMD_W-1:0] OP_MRS    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TIM_W-1:0] timing_cfg,
  input  logic [CFG_W-1:0] grp0_cfg,
  input  logic [CMD_W-1:0] preset_cmd,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_word,
  output logic [TIM_W-1:0] timing_out,
  output logic             done
);
  localparam int PWRUP_CYC = ns_to_cycles(PWRUP_NS, CLK_MHZ);
  localparam int GAP_CYC   = ns_to_cycles(GAP_NS, CLK_MHZ);
  localparam int CNT_MAX   = max_u(PWRUP_CYC, GAP_CYC);
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam logic [TIM_W-1:0] REF_MASK = TIM_W'(3) << REF_LSB;

  logic             cnt_load, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  logic [CMD_W-1:0] mrs_word;
  logic             seq_idle, seq_done;

  sdram_init_modecalc #(.CMD_W(CMD_W), .OP_MRS(OP_MRS)) u_mode (
    .cl_field   (timing_cfg[2:0]),
    .half_width (grp0_cfg[WIDTH_BIT]),
    .preset_cmd (preset_cmd),
    .mrs_word   (mrs_word)
  );

  sdram_init_delay #(.CNT_W(CNT_W)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  sdram_init_fsm #(
    .PWRUP_CYC (PWRUP_CYC), .GAP_CYC (GAP_CYC), .REF_BURST (REF_BURST),
    .CMD_W (CMD_W), .CNT_W (CNT_W),
    .OP_NOP (OP_NOP), .OP_PRE (OP_PRE), .OP_REF (OP_REF), .OP_MRS (OP_MRS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mrs_word  (mrs_word),
    .cnt_zero  (cnt_zero),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .idle      (seq_idle),
    .done      (seq_done)
  );

  // Refresh stays gated until the whole list has gone out.
  assign timing_out = seq_done ? timing_cfg : (timing_cfg & ~REF_MASK);
  assign done       = seq_done;
endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
  parameter int               GAP_CYC = 8,
  parameter int               CMD_W   = 32,
  parameter int               TIM_W   = 32,
  parameter int               REF_LSB = 12,
  parameter logic [CMD_W-1:0] OP_NOP  = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             idle,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_word,
  input logic [TIM_W-1:0] timing_cfg,
  input logic [TIM_W-1:0] timing_out,
  input logic             done
);
  localparam logic [TIM_W-1:0] REF_MASK = TIM_W'(3) << REF_LSB;

  logic [31:0] since_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (cmd_valid) begin
      since_q <= 32'd1;
      seen_q  <= 1'b1;
    end else if (since_q != 32'hFFFF_FFFF) begin
      since_q <= since_q + 1'b1;
    end
  end

  p_refresh_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ((timing_out & REF_MASK) == '0));
  p_refresh_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (timing_out == timing_cfg));
  p_start_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> (cmd_valid && cmd_word == OP_NOP));
  p_cmd_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && seen_q) |-> (since_q >= 32'(GAP_CYC)));
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);
endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
  .GAP_CYC (GAP_CYC), .CMD_W (CMD_W), .TIM_W (TIM_W),
  .REF_LSB (REF_LSB), .OP_NOP (OP_NOP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .idle       (seq_idle),
  .cmd_valid  (cmd_valid),
  .cmd_word   (cmd_word),
  .timing_cfg (timing_cfg),
  .timing_out (timing_out),
  .done       (done)
);

// File: tb/sdram_powerup_seq_bench.sv
module sdram_powerup_seq_bench;
  // Bench uses a shortened power-up delay and a gap that needs rounding up.
  localparam int P  = (20000 * 125 + 999) / 1000;  // 2500
  localparam int G  = (76 * 125 + 999) / 1000;     // 9.5 -> 10
  localparam int NV = 5;
  localparam logic [31:0] RMASK = 32'h0000_3000;

  // {timing_cfg, grp0_cfg, preset_cmd, expected mode-set word}
  localparam logic [127:0] VEC [NV] = '{
    {32'h0000_3002, 32'h0000_0000, 32'h0, 32'h103},  // CL2, 32-bit
    {32'h0000_1003, 32'h0000_0200, 32'h0, 32'h0C3},  // CL3, 16-bit
    {32'h0000_2002, 32'h0000_0200, 32'h0, 32'h083},  // CL2, 16-bit
    {32'h0000_3005, 32'hFFFF_FDFF, 32'h0, 32'h183},  // CL field 5 -> CL3, 32-bit
    {32'h0000_3002, 32'h0000_0000, 32'hABF, 32'hABF} // preset overrides
  };

  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] timing_cfg = 0, grp0_cfg = 0, preset_cmd = 0;
  logic        cmd_valid, done;
  logic [31:0] cmd_word, timing_out;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int ev_n, mask_bad, done_cyc;
  int ev_cyc [16];
  logic [31:0] ev_word [16];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_powerup_seq #(.CLK_MHZ(125), .PWRUP_NS(20000), .GAP_NS(76)) u_sdram_powerup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .timing_cfg(timing_cfg),
    .grp0_cfg(grp0_cfg), .preset_cmd(preset_cmd), .cmd_valid(cmd_valid),
    .cmd_word(cmd_word), .timing_out(timing_out), .done(done));

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) begin
      if (ev_n < 16) begin ev_cyc[ev_n] = cyc; ev_word[ev_n] = cmd_word; end
      ev_n = ev_n + 1;
    end
    if (!done && timing_out != (timing_cfg & ~RMASK)) mask_bad = mask_bad + 1;
    if (done && done_cyc < 0) done_cyc = cyc;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic run(input logic [127:0] v, input string tag, input bit poke);
    int t0;
    bit order_ok, space_ok;
    rst_n = 0;
    {timing_cfg, grp0_cfg, preset_cmd} = v[127:32];
    repeat (3) @(negedge clk);
    chk(cmd_valid == 0 && done == 0, "R12 reset outputs", {cmd_valid, done}, 0);
    chk(timing_out == (timing_cfg & ~RMASK), "R1 gated in reset", timing_out, timing_cfg & ~RMASK);
    rst_n = 1;
    ev_n = 0; mask_bad = 0; done_cyc = -1;
    @(negedge clk) start = 1; t0 = cyc;
    @(negedge clk) start = 0;
    if (poke) begin repeat (100) @(negedge clk); pulse_start(); end
    for (int i = 0; i < P + 12 * G + 50 && !done; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    pulse_start();                       // R11: start after done
    repeat (20) @(negedge clk);
    chk(ev_n == 11, {"R4 R11 strobe count ", tag}, ev_n, 11);
    if (ev_n == 11) begin
      chk(ev_word[0] == 0 && ev_cyc[0] == t0 + 1, {"R2 NOP timing ", tag}, ev_cyc[0] - t0, 1);
      chk(ev_cyc[1] - ev_cyc[0] == P, {"R3 power-up wait ", tag}, ev_cyc[1] - ev_cyc[0], P);
      order_ok = (ev_word[1] == 1);
      space_ok = 1;
      for (int k = 2; k <= 9; k++) order_ok &= (ev_word[k] == 2);
      for (int k = 2; k <= 10; k++) space_ok &= (ev_cyc[k] - ev_cyc[k-1] == G);
      chk(order_ok, {"R4 list order ", tag}, {ev_word[1], ev_word[2]}, {32'd1, 32'd2});
      chk(space_ok, {"R5 R11 list spacing ", tag}, ev_cyc[10] - ev_cyc[1], 9 * G);
      chk(ev_word[10] == v[31:0], {"R6 R7 R8 R9 mode word ", tag}, ev_word[10], v[31:0]);
      chk(done_cyc == ev_cyc[10] + G, {"R10 done cycle ", tag}, done_cyc - t0, 1 + P + 10 * G);
    end
    chk(done == 1, {"R10 done sticky ", tag}, done, 1);
    chk(timing_out == timing_cfg, {"R1 refresh released ", tag}, timing_out, timing_cfg);
    chk(mask_bad == 0, {"R1 refresh gated during run ", tag}, mask_bad, 0);
  endtask

  initial begin
    ev_n = 0; mask_bad = 0; done_cyc = -1;
    for (int i = 0; i < NV; i++) run(VEC[i], $sformatf("vec%0d", i), 1'b0);
    // Directed: start pulses mid-run must not disturb the sequence (R11).
    run(VEC[1], "midrun_start", 1'b1);
    // Directed: reset mid-run returns to the quiet state (R12).
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    pulse_start();
    repeat (50) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(cmd_valid == 0 && done == 0, "R12 reset mid-run", {cmd_valid, done}, 0);
    repeat (P + 20) @(negedge clk);
    chk(cmd_valid == 0 && done == 0, "R12 held in reset", {cmd_valid, done}, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule